// File: doc/BRIEF.md
# Page-buffered flash write sequencer

This block models, one clock at a time, the write and read paths of a byte-wide flash memory that is programmed a whole page at a time. A host drives active-low chip-select, write-strobe and read-strobe lines together with an address and a data byte. Each write strobe drops one byte into a page buffer. When the host stops writing for a set number of cycles, the block commits the entire page to its array in one step. For a fixed number of cycles around that commit it raises a busy flag.

The low address bits pick the byte within a page and the high bits pick the page. Every byte of a loaded page is programmed at once. Any offset the host did not load reads back as FFh. Reads are combinational from the array and come with an output-enable that a pad ring would use to steer a tri-state driver. Durations that are microseconds or milliseconds on silicon are given here as clock-count parameters, so that simulations stay short. The default address width is small for the same reason. Setting `ADDR_W` to 17 gives the full-size 128K-byte part.

Top module: `flash_page_writer`

## Requirements
- R1: A page holds 2**PAGE_W bytes (128 by default). addr[PAGE_W-1:0] is the byte offset and addr[ADDR_W-1:PAGE_W] is the page number.
- R2: A write cycle is any sampled cycle with ce_n=0, we_n=0 and oe_n=1. The address is taken from the first such cycle and the data from the last one. The byte is accepted on the first cycle after the strobe ends.
- R3: Bytes may be loaded in any offset order, and each loaded byte lands at its own offset.
- R4: The block stays in the load phase while each new write begins within LOAD_TO cycles of the previous one ending. Once the last accepted byte's strobe ends, busy rises after exactly LOAD_TO further inactive cycles.
- R5: At commit, each loaded offset of the page takes its loaded value and every other offset becomes FFh. Array contents seen by reads do not change until busy falls.
- R6: busy stays high for exactly PROG_CYCLES cycles for each program cycle.
- R7: When ce_n=0 and oe_n=0, dout_en is 1 and dout is the array byte at addr. Otherwise dout_en is 0 and dout is 00h.
- R8: During a load phase, a byte whose page number differs from the first byte's page is discarded and does not restart the inactivity timer. It sets page_err, which stays set until reset.
- R9: A write cycle that ends while busy is high is dropped: it neither starts a new load phase nor changes any array byte.
- R10: Each new load phase starts from an all-FFh buffer, so bytes loaded in an earlier phase are not carried into the next program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Byte address: page number in the high bits, offset in the low PAGE_W bits |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 00h when not enabled |
| dout_en | output | 1 | Read data valid / output driver enable |
| busy | output | 1 | Internal program cycle in progress |
| page_err | output | 1 | Sticky flag: a byte for a different page was discarded |

## Verification
Some properties are checked on every cycle:
- the length of each busy interval;
- that page_err stays set once set;
- that page_err only rises right after a write strobe ends outside a program cycle;
- that read data stays steady for a fixed address while busy is high;
- that the bus is idle whenever either select is inactive.

Other behaviour can only be shown by the bench's scenarios:
- which bytes land where, and the FFh fill for offsets never loaded;
- the address-first and data-last capture rule;
- the exact cycle at which the inactivity timeout starts programming;
- discarded cross-page bytes;
- dropped writes while busy;
- the clearing of the buffer between load phases.

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 7,
  parameter int LOAD_TO     = 40,
  parameter int PROG_CYCLES = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int CNT_MAX    = (LOAD_TO > PROG_CYCLES) ? LOAD_TO : PROG_CYCLES;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t               st;
  logic              wr_q;
  logic [ADDR_W-1:0] a_lat;
  logic [7:0]        d_lat;
  logic [PG_W-1:0]   pg;
  logic [PAGE_BYTES-1:0] vld;
  logic [7:0]        pbuf [PAGE_BYTES];
  logic [7:0]        mem  [DEPTH];
  logic [CNT_W-1:0]  tmr;

  logic              wr_act, wr_start, wr_end;
  logic [PG_W-1:0]   l_pg;
  logic [PAGE_W-1:0] l_off;
  logic              take, commit, tmo;

  assign wr_act   = ~ce_n & ~we_n & oe_n;
  assign wr_start = wr_act & ~wr_q;
  assign wr_end   = ~wr_act & wr_q;
  assign l_pg     = a_lat[ADDR_W-1:PAGE_W];
  assign l_off    = a_lat[PAGE_W-1:0];
  assign take     = wr_end & ((st == S_IDLE) | ((st == S_LOAD) & (l_pg == pg)));
  assign commit   = (st == S_PROG) && (tmr == CNT_W'(PROG_CYCLES - 1));
  assign tmo      = (st == S_LOAD) && !wr_act && !wr_q && (tmr == CNT_W'(LOAD_TO - 1));
  assign busy     = (st == S_PROG);
  assign dout_en  = ~ce_n & ~oe_n;
  assign dout     = dout_en ? mem[addr] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      a_lat <= '0;
      d_lat <= '0;
    end else begin
      wr_q <= wr_act;
      if (wr_start) a_lat <= addr;
      if (wr_act)   d_lat <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      pg       <= '0;
      vld      <= '0;
      page_err <= 1'b0;
    end else if (take) begin
      tmr <= '0;
      if (st == S_IDLE) begin
        pg  <= l_pg;
        vld <= PAGE_BYTES'(1) << l_off;
        st  <= S_LOAD;
      end else begin
        vld[l_off] <= 1'b1;
      end
    end else begin
      case (st)
        S_LOAD: begin
          if (wr_end)                page_err <= 1'b1;
          else if (wr_act || wr_q)   tmr <= tmr;
          else if (tmo) begin
            st  <= S_PROG;
            tmr <= '0;
          end else                   tmr <= tmr + 1'b1;
        end
        S_PROG: begin
          if (commit) begin
            st  <= S_IDLE;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) pbuf[l_off] <= d_lat;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        mem[{pg, PAGE_W'(i)}] <= vld[i] ? pbuf[i] : 8'hFF;
    end
  end
endmodule

// File: rtl/flash_page_writer_chk.sv
module flash_page_writer_chk #(
  parameter int ADDR_W      = 10,
  parameter int PROG_CYCLES = 60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dout,
  input logic              dout_en,
  input logic              busy,
  input logic              page_err
);
  localparam int BW = $clog2(PROG_CYCLES + 1) + 1;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  // R6
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < BW'(PROG_CYCLES)));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == BW'(PROG_CYCLES)));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_err) |-> ($past(!ce_n && !we_n && oe_n, 2) && !$past(busy)));

  // R5
  hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(addr) && dout_en && $past(dout_en)) |-> $stable(dout));

  // R7
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (dout == 8'h00 && !dout_en));
endmodule

bind flash_page_writer flash_page_writer_chk #(
  .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .addr(addr), .dout(dout), .dout_en(dout_en), .busy(busy), .page_err(page_err)
);

// File: tb/flash_page_writer_tb_top.sv
`timescale 1ns/1ps
module flash_page_writer_tb_top;
  localparam int ADDR_W = 10;
  localparam int PAGE_W = 7;
  localparam int LOAD_TO = 40;
  localparam int PC = 60;
  localparam int NB = 1 << PAGE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en, busy, page_err;

  int checks = 0;
  int errors = 0;

  logic [7:0] emem [1 << ADDR_W];
  logic [7:0] bbuf [NB];
  logic [NB-1:0] bvld;
  int bpg = 0;
  bit loading = 0;

  always #2.5 clk = ~clk;

  flash_page_writer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LOAD_TO(LOAD_TO), .PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy), .page_err(page_err)
  );

  function automatic logic [ADDR_W-1:0] mk(input int p, input int o);
    return {3'(p), 7'(o)};
  endfunction

  function automatic logic [7:0] exp_byte(input int o);
    return bvld[o] ? bbuf[o] : 8'hFF;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mdl_write(input int p, input int o, input logic [7:0] d);
    if (!loading) begin bvld = '0; bpg = p; loading = 1; end
    if (p == bpg) begin bbuf[o] = d; bvld[o] = 1'b1; end
  endtask

  task automatic mdl_commit();
    for (int o = 0; o < NB; o++) emem[bpg*NB + o] = exp_byte(o);
    loading = 0;
  endtask

  task automatic do_write(input int p, input int o, input logic [7:0] d, input int hold);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = mk(p, o); din = d;
    repeat (hold - 1) @(negedge clk);
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input int p, input int o, output logic [7:0] v, output logic en);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = mk(p, o);
    #1; v = dout; en = dout_en;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_busy(input bit exact);
    int n = 0;
    do begin @(negedge clk); n++; end while (!busy && n < LOAD_TO + 20);
    if (exact) check(n == LOAD_TO + 1, "R4 busy start", n, LOAD_TO + 1);
    else       check(busy, "R4 busy start", busy, 1);
  endtask

  task automatic wait_idle(input bit cnt);
    int m = 0;
    while (busy && m < PC + 20) begin m++; @(negedge clk); end
    if (cnt) check(m == PC, "R6 busy length", m, PC);
  endtask

  task automatic check_page(input int p, input string req);
    logic [7:0] v; logic en;
    for (int o = 0; o < NB; o++) begin
      rd(p, o, v, en);
      check(en && v == emem[p*NB + o], req, v, emem[p*NB + o]);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v; logic en;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy, "R6 reset busy", busy, 0);
    check(!page_err, "R8 reset err", page_err, 0);
    check(!dout_en && dout == 0, "R7 reset bus", dout_en, 0);

    // R2: address from first active cycle, data from last
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = mk(2, 10); din = 8'h11;
    @(negedge clk); addr = mk(2, 20); din = 8'h22;
    @(negedge clk); din = 8'h3C;
    @(negedge clk); ce_n = 1; we_n = 1;
    mdl_write(2, 10, 8'h3C);
    // R3 out-of-order loads, R4 long gap still within window
    repeat (3) @(negedge clk);
    do_write(2, 127, 8'hA7, 1); mdl_write(2, 127, 8'hA7);
    repeat (LOAD_TO - 3) @(negedge clk);
    check(!busy, "R4 stays loading", busy, 0);
    do_write(2, 5, 8'h55, 2); mdl_write(2, 5, 8'h55);
    do_write(2, 0, 8'h01, 1); mdl_write(2, 0, 8'h01);
    wait_busy(1); wait_idle(1); mdl_commit();
    rd(2, 10, v, en); check(v == 8'h3C, "R2 data last", v, 8'h3C);
    rd(2, 20, v, en); check(v == 8'hFF, "R2 addr first", v, 8'hFF);
    check_page(2, "R1 R3 R5 page content");

    // R5 old data during busy, R9 write while busy, R10 cleared buffer
    do_write(2, 5, 8'h66, 1); mdl_write(2, 5, 8'h66);
    wait_busy(1);
    do_write(2, 127, 8'h33, 1);
    rd(2, 5, v, en); check(v == 8'h55, "R5 old data while busy", v, 8'h55);
    wait_idle(0); mdl_commit();
    rd(2, 5, v, en); check(v == 8'h66, "R5 new data", v, 8'h66);
    rd(2, 127, v, en); check(v == 8'hFF, "R10 buffer cleared", v, 8'hFF);
    repeat (LOAD_TO + PC + 10) @(negedge clk);
    check(!busy, "R9 busy write dropped", busy, 0);
    rd(2, 127, v, en); check(v == 8'hFF, "R9 array unchanged", v, 8'hFF);

    // R8 cross-page byte
    do_write(3, 1, 8'h11, 1); mdl_write(3, 1, 8'h11);
    do_write(4, 2, 8'h22, 1); mdl_write(4, 2, 8'h22);
    @(negedge clk);
    check(page_err, "R8 err set", page_err, 1);
    do_write(3, 3, 8'h33, 1); mdl_write(3, 3, 8'h33);
    wait_busy(1); wait_idle(1); mdl_commit();
    rd(3, 2, v, en); check(v == 8'hFF, "R8 byte discarded", v, 8'hFF);
    check_page(3, "R8 page content");
    check(page_err, "R8 err sticky", page_err, 1);

    // R7 read gating
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1; addr = mk(3, 1); #1;
    check(!dout_en && dout == 0, "R7 oe high", dout, 0);
    ce_n = 1; oe_n = 0; #1;
    check(!dout_en && dout == 0, "R7 ce high", dout, 0);
    oe_n = 1;
    rd(3, 1, v, en); check(en && v == 8'h11, "R7 read", v, 8'h11);

    // random pages
    for (int r = 0; r < 6; r++) begin
      int p = $urandom_range(0, 7);
      int nb = $urandom_range(1, 12);
      for (int k = 0; k < nb; k++) begin
        int o = $urandom_range(0, NB - 1);
        logic [7:0] d = 8'($urandom);
        do_write(p, o, d, $urandom_range(1, 3)); mdl_write(p, o, d);
        if (k != nb - 1) begin
          repeat ($urandom_range(0, LOAD_TO - 5)) @(negedge clk);
          check(!busy, "R4 random gap", busy, 0);
        end
      end
      wait_busy(1); wait_idle(1); mdl_commit();
      check_page(p, "R3 R5 R10 random page");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule